// File: doc/BRIEF.md
# Gated Event Counter Bank

A bank of event counters for performance monitoring. Every cycle each counter samples one event line that upstream logic has already chosen. Several gates decide whether counting happens in a cycle:

- a global freeze bit;
- per-privilege suppression (user or supervisor);
- a process-mark filter.

With the trigger bit set, counters 1 and up hold until counter 0 turns negative, meaning its most significant bit is set. Each counter can run in history mode instead of count mode. In history mode it shifts left every enabled cycle and takes the event bit into bit 0. A threshold event can replace a counter's event line. This event fires for a completed load/store whose latency is above a programmed cycle count, and an external gate pin can qualify it.

Software reaches the bank through a plain register port:

- Writes take effect at the next clock edge.
- Reads are combinational from `reg_addr_i`.
- Address 0 is the control word. Address k+1 is counter k. Other addresses read as zero.

Each negative counter shows on `neg_o`. When exceptions are enabled, any negative counter drives `ovf_req_o`. The bank can also freeze itself when that request fires. All pins are control or status pins with no flow control, so no back-pressure applies.

Control word fields (bit positions are fixed for the defaults NUM_CTR=4, THR_W=6):

| Bits | Field |
|------|-------|
| 0 | freeze |
| 1 | suppress in supervisor mode |
| 2 | suppress in user mode |
| 4:3 | mark filter: 01 = only when mark set, 10 = only when mark clear, 00/11 = always |
| 5 | trigger enable |
| 6 | exception enable |
| 7 | freeze on exception |
| 11:8 | history mode, one bit per counter k at bit 8+k |
| 15:12 | threshold-event select, one bit per counter k at bit 12+k |
| 21:16 | threshold value, in cycles |
| 22 | threshold gate enable |

Top module: `evctr_bank`

## Requirements
- R1: After reset the control word and all counters read zero, and `ovf_req_o` and `neg_o` are low.
- R2: In count mode an enabled counter whose event is high increments by exactly one per cycle. A counter at 0xFFFFFFFF wraps to 0.
- R3: A register write to a counter in a cycle where that counter would also increment loads the written value, and nothing is added. Reads return the register at `reg_addr_i` in the same cycle.
- R4: With bit 2 set, no counter changes while `usr_mode_i`=1. With bit 1 set, no counter changes while `usr_mode_i`=0.
- R5: With mark filter 01, counting happens only while `pmark_i`=1. With filter 10, counting happens only while `pmark_i`=0.
- R6: With bit 5 set, counters 1..N-1 do not count in any cycle that starts with counter 0 non-negative, until counter 0 has been seen negative. After that they keep counting until the control word is written again.
- R7: In history mode, on each enabled cycle the counter becomes {counter[30:0], event}.
- R8: `neg_o[k]` equals bit 31 of counter k. `ovf_req_o` is high when bit 6 is set and some counter is negative, and is low otherwise.
- R9: While bit 0 is set, no counter changes. With bits 6 and 7 set, a negative counter sets bit 0 on the next edge, and bit 0 stays set until software writes the control word.
- R10: A counter selected for the threshold event counts one per cycle in which `mem_done_i`=1, `mem_lat_i` is greater than the threshold value, and either bit 22 is clear or `thr_gate_i`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 4 | Selected event per counter, this cycle |
| usr_mode_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| pmark_i | input | 1 | Process-mark bit of the running process |
| mem_done_i | input | 1 | A load/store completes this cycle |
| mem_lat_i | input | 8 | Latency in cycles of the completing access |
| thr_gate_i | input | 1 | External qualifier for the threshold event |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| neg_o | output | 4 | Per-counter negative flag |
| ovf_req_o | output | 1 | Monitor exception request |

## Verification
The bench goes after the following corner cases, each with its failure symptom:

- **Write colliding with an event.** A design that adds after loading reads 101 instead of 100.
- **Wrap from all ones.** A design that saturates holds 0xFFFFFFFF instead of wrapping to zero.
- **Trigger timing.** The cycle in which counter 0 first turns negative must not yet count on counter 1. A design that gates on the next value counts one too many. A design without the sticky trigger stops once counter 0 is rewritten.
- **History shift.** The shifted history must come out as 0xB for events 1,0,1,1. A design that counts instead would read 3.
- **Self-freeze and threshold.** The self-set freeze must survive later events. The threshold compare must be strict and must respect the gate: a design that uses `>=` or ignores the gate counts extra accesses.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  typedef enum logic [1:0] {
    MARK_ANY  = 2'b00,
    MARK_SET  = 2'b01,
    MARK_CLR  = 2'b10,
    MARK_ANYB = 2'b11
  } mark_mode_e;

  localparam int FRZ_BIT   = 0;
  localparam int NOSUP_BIT = 1;
  localparam int NOUSR_BIT = 2;
  localparam int MARK_LSB  = 3;
  localparam int TRIG_BIT  = 5;
  localparam int EXC_BIT   = 6;
  localparam int FOE_BIT   = 7;
  localparam int HIST_LSB  = 8;
endpackage

// File: rtl/evctr_gate.sv
module evctr_gate
  import evctr_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             no_sup,
  input  logic             no_usr,
  input  mark_mode_e       mark_mode,
  input  logic             usr_mode,
  input  logic             pmark,
  input  logic [THR_W-1:0] thr_val,
  input  logic             gate_en,
  input  logic             gate_pin,
  input  logic             mem_done,
  input  logic [LAT_W-1:0] mem_lat,
  output logic             run,
  output logic             thr_evt
);
  localparam int CW = LAT_W + THR_W;

  logic mark_ok;
  logic priv_ok;

  always_comb begin
    unique case (mark_mode)
      MARK_SET: mark_ok = pmark;
      MARK_CLR: mark_ok = !pmark;
      default:  mark_ok = 1'b1;
    endcase
    priv_ok = usr_mode ? !no_usr : !no_sup;
    run     = !freeze && priv_ok && mark_ok;
    thr_evt = mem_done && (CW'(mem_lat) > CW'(thr_val)) && (!gate_en || gate_pin);
  end

  AST_THR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_evt |-> mem_done) else $error("threshold event without access"); // R10
  AST_FRZ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !run) else $error("run while frozen"); // R9
endmodule

// File: rtl/evctr_cell.sv
module evctr_cell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         cnt_en,
  input  logic         hist,
  input  logic         evt,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_o <= '0;
    else if (wr_en)      cnt_o <= wdata;
    else if (cnt_en) begin
      if (hist)          cnt_o <= {cnt_o[W-2:0], evt};
      else if (evt)      cnt_o <= cnt_o + ONE;
    end
  end

  AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_o == $past(wdata)) else $error("write lost"); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !hist && cnt_en) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + ONE))
    else $error("count step"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cnt_en) |=> $stable(cnt_o)) else $error("moved while disabled"); // R9
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && hist && cnt_en) |=> cnt_o[W-1:1] == $past(cnt_o[W-2:0]))
    else $error("history shift"); // R7
endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int LAT_W   = 8,
  parameter int THR_W   = 6,
  localparam int ADDR_W = $clog2(NUM_CTR + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] evt_i,
  input  logic               usr_mode_i,
  input  logic               pmark_i,
  input  logic               mem_done_i,
  input  logic [LAT_W-1:0]   mem_lat_i,
  input  logic               thr_gate_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [CTR_W-1:0]   reg_wdata_i,
  output logic [CTR_W-1:0]   reg_rdata_o,
  output logic [NUM_CTR-1:0] neg_o,
  output logic               ovf_req_o
);
  localparam int THSEL_LSB = HIST_LSB + NUM_CTR;
  localparam int THR_LSB   = THSEL_LSB + NUM_CTR;
  localparam int GATE_BIT  = THR_LSB + THR_W;

  logic [CTR_W-1:0] ctrl_q;
  logic [CTR_W-1:0] cnt [NUM_CTR];
  logic             wr_ctrl;
  logic             trig_seen;
  logic             go;
  logic             run;
  logic             thr_evt;
  logic             exc_en;

  assign wr_ctrl   = reg_wr_i && (reg_addr_i == '0);
  assign exc_en    = ctrl_q[EXC_BIT];
  assign ovf_req_o = exc_en && (|neg_o);
  assign go        = !ctrl_q[TRIG_BIT] || trig_seen || cnt[0][CTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      trig_seen <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q    <= reg_wdata_i;
      trig_seen <= 1'b0;
    end else begin
      if (ovf_req_o && ctrl_q[FOE_BIT]) ctrl_q[FRZ_BIT] <= 1'b1;
      if (ctrl_q[TRIG_BIT] && cnt[0][CTR_W-1]) trig_seen <= 1'b1;
    end
  end

  evctr_gate #(.LAT_W(LAT_W), .THR_W(THR_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (ctrl_q[FRZ_BIT]),
    .no_sup   (ctrl_q[NOSUP_BIT]),
    .no_usr   (ctrl_q[NOUSR_BIT]),
    .mark_mode(mark_mode_e'(ctrl_q[MARK_LSB +: 2])),
    .usr_mode (usr_mode_i),
    .pmark    (pmark_i),
    .thr_val  (ctrl_q[THR_LSB +: THR_W]),
    .gate_en  (ctrl_q[GATE_BIT]),
    .gate_pin (thr_gate_i),
    .mem_done (mem_done_i),
    .mem_lat  (mem_lat_i),
    .run      (run),
    .thr_evt  (thr_evt)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic en_k;
    logic ev_k;
    logic wr_k;
    assign en_k = run && ((k == 0) || go);
    assign ev_k = ctrl_q[THSEL_LSB + k] ? thr_evt : evt_i[k];
    assign wr_k = reg_wr_i && (reg_addr_i == ADDR_W'(k + 1));

    evctr_cell #(.W(CTR_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_k),
      .wdata (reg_wdata_i),
      .cnt_en(en_k),
      .hist  (ctrl_q[HIST_LSB + k]),
      .evt   (ev_k),
      .cnt_o (cnt[k])
    );
    assign neg_o[k] = cnt[k][CTR_W-1];

    if (k > 0) begin : g_trig_chk
      AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[TRIG_BIT] && !trig_seen && !cnt[0][CTR_W-1] && !reg_wr_i) |=> $stable(cnt[k]))
        else $error("counted before trigger"); // R6
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == '0) reg_rdata_o = ctrl_q;
    for (int k = 0; k < NUM_CTR; k++)
      if (reg_addr_i == ADDR_W'(k + 1)) reg_rdata_o = cnt[k];
  end

  AST_FRZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[FRZ_BIT] && !wr_ctrl) |=> ctrl_q[FRZ_BIT]) else $error("freeze dropped"); // R9
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_o == '0) |-> !ovf_req_o) else $error("request without negative"); // R8
endmodule

// File: tb/sim_evctr_bank.sv
module sim_evctr_bank;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt_i = '0;
  logic        usr_mode_i = 1'b0;
  logic        pmark_i = 1'b0;
  logic        mem_done_i = 1'b0;
  logic [7:0]  mem_lat_i = '0;
  logic        thr_gate_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [3:0]  neg_o;
  logic        ovf_req_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  evctr_bank u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .usr_mode_i(usr_mode_i),
    .pmark_i(pmark_i), .mem_done_i(mem_done_i), .mem_lat_i(mem_lat_i),
    .thr_gate_i(thr_gate_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .neg_o(neg_o),
    .ovf_req_o(ovf_req_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    #1 chk(reg_rdata_o, exp, tag);
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    @(negedge clk);
    evt_i = m;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  task automatic clr_all();
    wr(3'd0, 32'h0);
    for (int a = 1; a <= 4; a++) wr(3'(a), 32'h0);
  endtask

  task automatic t_reset();
    rd_chk(3'd0, 32'h0, "R1 ctrl");
    for (int a = 1; a <= 4; a++) rd_chk(3'(a), 32'h0, "R1 counter");
    chk({31'h0, ovf_req_o}, 32'h0, "R1 ovf_req");
    chk({28'h0, neg_o}, 32'h0, "R1 neg");
  endtask

  task automatic t_count();
    clr_all();
    pulse(4'b0001, 3);
    pulse(4'b0010, 1);
    rd_chk(3'd1, 32'd3, "R2 ctr0 three events");
    rd_chk(3'd2, 32'd1, "R2 ctr1 one event");
    wr(3'd4, 32'hFFFF_FFFF);
    pulse(4'b1000, 1);
    rd_chk(3'd4, 32'h0, "R2 wrap");
  endtask

  task automatic t_wrprio();
    clr_all();
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 3'd1; reg_wdata_i = 32'd100; evt_i = 4'b0001;
    @(negedge clk);
    reg_wr_i = 1'b0; evt_i = '0;
    #1 chk(reg_rdata_o, 32'd100, "R3 write beats increment");
    pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd101, "R3 count after write");
  endtask

  task automatic t_priv();
    clr_all();
    wr(3'd0, 32'h4);
    usr_mode_i = 1'b1; pulse(4'b0001, 2);
    rd_chk(3'd1, 32'd0, "R4 user suppressed");
    usr_mode_i = 1'b0; pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd1, "R4 supervisor counts");
    wr(3'd0, 32'h2);
    pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd1, "R4 supervisor suppressed");
    usr_mode_i = 1'b1; pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd2, "R4 user counts");
    usr_mode_i = 1'b0;
  endtask

  task automatic t_mark();
    clr_all();
    wr(3'd0, 32'h8);
    pmark_i = 1'b0; pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd0, "R5 mark-set filter, mark clear");
    pmark_i = 1'b1; pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd1, "R5 mark-set filter, mark set");
    wr(3'd0, 32'h10);
    pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd1, "R5 mark-clear filter, mark set");
    pmark_i = 1'b0; pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd2, "R5 mark-clear filter, mark clear");
  endtask

  task automatic t_trig();
    clr_all();
    wr(3'd1, 32'h7FFF_FFFF);
    wr(3'd0, 32'h20);
    @(negedge clk); reg_addr_i = 3'd2; evt_i = 4'b0010;
    repeat (2) @(negedge clk);
    evt_i = 4'b0011;
    @(negedge clk);
    evt_i = 4'b0010;
    #1 chk(reg_rdata_o, 32'd0, "R6 held until counter 0 negative");
    chk({28'h0, neg_o}, 32'h1, "R8 neg flag counter 0");
    chk({31'h0, ovf_req_o}, 32'h0, "R8 no request with exceptions off");
    repeat (2) @(negedge clk);
    evt_i = '0;
    #1 chk(reg_rdata_o, 32'd2, "R6 counts after trigger");
    wr(3'd1, 32'h0);
    pulse(4'b0010, 1);
    rd_chk(3'd2, 32'd3, "R6 trigger sticky");
  endtask

  task automatic t_hist();
    clr_all();
    wr(3'd0, 32'h400);
    wr(3'd3, 32'h0);
    @(negedge clk); reg_addr_i = 3'd3; evt_i = 4'b0100;
    @(negedge clk); evt_i = 4'b0000;
    @(negedge clk); evt_i = 4'b0100;
    @(negedge clk);
    @(negedge clk); evt_i = 4'b0000;
    #1 chk(reg_rdata_o, 32'hB, "R7 history 1011");
  endtask

  task automatic t_exc();
    clr_all();
    wr(3'd4, 32'h7FFF_FFFF);
    wr(3'd0, 32'hC0);
    pulse(4'b1000, 1);
    #1 chk({31'h0, ovf_req_o}, 32'h1, "R8 request on negative");
    chk({28'h0, neg_o}, 32'h8, "R8 neg flag counter 3");
    rd_chk(3'd0, 32'hC1, "R9 freeze self-set");
    pulse(4'b0001, 2);
    rd_chk(3'd1, 32'd0, "R9 frozen counter holds");
    rd_chk(3'd0, 32'hC1, "R9 freeze sticky");
    wr(3'd0, 32'h0);
    #1 chk({31'h0, ovf_req_o}, 32'h0, "R8 request off with exceptions off");
    pulse(4'b0001, 1);
    rd_chk(3'd1, 32'd1, "R9 counts after unfreeze");
    wr(3'd0, 32'h1);
    pulse(4'b1111, 2);
    rd_chk(3'd1, 32'd1, "R9 software freeze");
  endtask

  task automatic memop(input logic [7:0] lat, input logic g);
    @(negedge clk);
    mem_done_i = 1'b1; mem_lat_i = lat; thr_gate_i = g;
    @(negedge clk);
    mem_done_i = 1'b0;
  endtask

  task automatic t_thr();
    clr_all();
    wr(3'd0, 32'h0040_2000 | (32'd5 << 16));
    memop(8'd6, 1'b1);
    memop(8'd5, 1'b1);
    memop(8'd9, 1'b0);
    memop(8'd200, 1'b1);
    rd_chk(3'd2, 32'd2, "R10 threshold strict and gated");
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_wrprio();
    t_priv();
    t_mark();
    t_trig();
    t_hist();
    t_exc();
    t_thr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule